// File: doc/BRIEF.md
# Level-Triggered DMA Request Acceptance Sequencer

This block sits in front of one DMA channel. It watches an active-low, level-sensitive request pin and turns it into single-address transfers, one at a time. After the write that enables the channel has finished, the block opens an acceptance window. In that window the pin is sampled on every rising clock edge, and a low sample is stored as a held request. When the bus arbiter then grants a bus break, the held request is consumed and the block sends a one-clock start pulse to the bus cycle engine.

From the moment the request is consumed until the transfer cycle reports completion, acceptance stays closed and the pin is not looked at. This closed stretch always lasts at least `MIN_CLR` clock cycles, even when the engine reports completion at once. This gives external logic time to withdraw the request level, so that a request still asserted from the previous transfer is not counted twice. When the transfer completes with the terminal-count input high, the sequencer goes back to idle and waits for a new enabling write. Otherwise it reopens acceptance and the loop repeats.

Top module: `dma_lvl_req_seq`

## Requirements
- R1: While `rst` is high, and after it until the first enabling strobe, `held_req`, `start_xfer` and `busy` are 0, whatever the level of `req_n`.
- R2: An `en_wr_done` pulse seen at a clock edge while idle opens acceptance. The pin is first sampled at the following edge, so a low level present only in the strobe cycle is not taken.
- R3: While acceptance is open, a low `req_n` at a rising edge sets `held_req` (visible after that edge). It then stays set, whatever the pin does, until it is consumed.
- R4: `start_xfer` is high in exactly those cycles where acceptance is open, `held_req` is 1 and `bus_brk` is 1. At the edge that ends such a cycle, `held_req` clears and `busy` rises.
- R5: `start_xfer` never lasts more than one cycle, and each acceptance window gives at most one start.
- R6: While `busy` is 1, the `req_n` level has no effect. `held_req` stays 0 throughout.
- R7: `busy` falls at the first edge at which `xfer_done` has been seen (at that edge or earlier in the transfer) and at least `MIN_CLR` (default 2) edges have passed since the edge that consumed the request. If `busy` falls without terminal count, acceptance reopens and the pin is sampled again from the next edge.
- R8: If `tc` is high in a cycle in which `xfer_done` is high during a transfer, the sequencer returns to idle when `busy` falls. The pin is then ignored until a new `en_wr_done`.
- R9: `en_wr_done` while acceptance is open or busy, and `xfer_done` while not busy, have no effect.
- R10: With `req_n` held low continuously, the number of start pulses equals the number of acceptance windows that were consumed, which is one per completed transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en_wr_done | input | 1 | Pulse marking the end of the channel-enabling write |
| req_n | input | 1 | Active-low level request pin |
| bus_brk | input | 1 | Bus break granted by the arbiter |
| xfer_done | input | 1 | Single transfer cycle completed |
| tc | input | 1 | Transfer count exhausted, qualified by `xfer_done` |
| held_req | output | 1 | A sampled request is being held |
| start_xfer | output | 1 | One-cycle start to the bus cycle engine |
| busy | output | 1 | Transfer in flight; acceptance closed |

## Verification
`start_xfer` is combinational from the current `bus_brk` and the registered state, so it is due in the same cycle as the grant. `held_req` and `busy` change one edge after the sample, grant or completion that causes them. The bench drives inputs just after the falling edge and compares all three outputs 1 ns later. It then advances a behavioural model at the rising edge. Every expected value therefore comes from the state the model held before that edge, together with the inputs present during the cycle. The minimum closed window is exercised by returning `xfer_done` in the very cycle after a start, which must still hold `busy` for two edges.

// File: rtl/dma_lvl_pkg.sv
package dma_lvl_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_OPEN = 2'd1,
        SEQ_XFER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic accept_open;
        logic busy;
        logic start;
    } seq_ctl_t;

    function automatic seq_ctl_t decode_state(seq_state_e st, logic held, logic brk);
        seq_ctl_t c;
        c.accept_open = (st == SEQ_OPEN);
        c.busy        = (st == SEQ_XFER);
        c.start       = (st == SEQ_OPEN) && held && brk;
        return c;
    endfunction

endpackage

// File: rtl/dma_lvl_sampler.sv
module dma_lvl_sampler (
    input  logic clk,
    input  logic rst,
    input  logic accept_open,
    input  logic req_n,
    input  logic consume,
    output logic held_o
);
    logic held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
        end else if (consume) begin
            held_q <= 1'b0;
        end else if (accept_open && !req_n) begin
            held_q <= 1'b1;
        end
    end

    assign held_o = held_q;

    // a held request may only appear after a cycle with acceptance open
    assert_held_only_open_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(held_q) |-> $past(accept_open));

endmodule

// File: rtl/dma_lvl_window.sv
module dma_lvl_window #(
    parameter int MIN_CLR = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic active,
    input  logic xfer_done,
    input  logic tc,
    output logic release_o,
    output logic last_o
);
    localparam int CW = $clog2(MIN_CLR + 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(MIN_CLR - 1);
    localparam logic [CW-1:0] GAP_MAX  = CW'(MIN_CLR);

    logic [CW-1:0] gap_q;
    logic          done_q;
    logic          tc_q;
    logic          done_any;
    logic          tc_any;

    assign done_any  = done_q | xfer_done;
    assign tc_any    = tc_q | (xfer_done & tc);
    assign release_o = active && done_any && (gap_q >= GAP_LAST);
    assign last_o    = tc_any;

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            gap_q  <= '0;
            done_q <= 1'b0;
            tc_q   <= 1'b0;
        end else if (active && !release_o) begin
            if (gap_q != GAP_MAX) begin
                gap_q <= gap_q + 1'b1;
            end
            done_q <= done_any;
            tc_q   <= tc_any;
        end
    end

    // completion latched before the minimum gap must survive until release
    assert_done_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (active && xfer_done && !release_o && !arm) |=> done_q);

endmodule

// File: rtl/dma_lvl_fsm.sv
module dma_lvl_fsm
    import dma_lvl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en_wr_done,
    input  logic     held,
    input  logic     bus_brk,
    input  logic     release_i,
    input  logic     last_i,
    output seq_ctl_t ctl_o
);
    seq_state_e state_q;
    seq_state_e state_d;
    seq_ctl_t   ctl;

    assign ctl   = decode_state(state_q, held, bus_brk);
    assign ctl_o = ctl;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (en_wr_done) state_d = SEQ_OPEN;
            SEQ_OPEN: if (ctl.start)  state_d = SEQ_XFER;
            SEQ_XFER: if (release_i)  state_d = last_i ? SEQ_IDLE : SEQ_OPEN;
            default:                  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    // strobes outside idle never change the sequencing state
    assert_strobe_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEQ_OPEN && !ctl.start) |=> state_q == SEQ_OPEN);

endmodule

// File: rtl/dma_lvl_req_seq.sv
module dma_lvl_req_seq
    import dma_lvl_pkg::*;
#(
    parameter int MIN_CLR = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en_wr_done,
    input  logic req_n,
    input  logic bus_brk,
    input  logic xfer_done,
    input  logic tc,
    output logic held_req,
    output logic start_xfer,
    output logic busy
);
    seq_ctl_t ctl;
    logic     held;
    logic     win_release;
    logic     win_last;

    dma_lvl_sampler u_sampler (
        .clk        (clk),
        .rst        (rst),
        .accept_open(ctl.accept_open),
        .req_n      (req_n),
        .consume    (ctl.start),
        .held_o     (held)
    );

    dma_lvl_window #(.MIN_CLR(MIN_CLR)) u_window (
        .clk      (clk),
        .rst      (rst),
        .arm      (ctl.start),
        .active   (ctl.busy),
        .xfer_done(xfer_done),
        .tc       (tc),
        .release_o(win_release),
        .last_o   (win_last)
    );

    dma_lvl_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en_wr_done(en_wr_done),
        .held      (held),
        .bus_brk   (bus_brk),
        .release_i (win_release),
        .last_i    (win_last),
        .ctl_o     (ctl)
    );

    assign held_req   = held;
    assign start_xfer = ctl.start;
    assign busy       = ctl.busy;

    assert_start_needs_held_R4: assert property (@(posedge clk) disable iff (rst)
        start_xfer |-> (held_req && bus_brk));

    assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
        start_xfer |=> !start_xfer);

    assert_busy_after_start_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_xfer));

    assert_min_window_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(busy, 2));

    assert_no_held_busy_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !held_req);

endmodule

// File: tb/dma_lvl_req_seq_test.sv
module dma_lvl_req_seq_test;
    localparam int MIN_CLR = 2;

    logic clk = 1'b0;
    logic rst, en_wr_done, req_n, bus_brk, xfer_done, tc;
    logic held_req, start_xfer, busy;

    always #4 clk = ~clk;

    dma_lvl_req_seq #(.MIN_CLR(MIN_CLR)) uut (
        .clk(clk), .rst(rst), .en_wr_done(en_wr_done), .req_n(req_n),
        .bus_brk(bus_brk), .xfer_done(xfer_done), .tc(tc),
        .held_req(held_req), .start_xfer(start_xfer), .busy(busy)
    );

    int    vectors = 0;
    int    miscompares = 0;
    string tag = "R1";

    // behavioural reference: mode 0 idle, 1 accepting, 2 transfer in flight
    int m_mode = 0;
    bit m_held = 0;
    int m_since = 0;
    bit m_done = 0;
    bit m_tc = 0;
    int m_windows = 0;
    int dut_starts = 0;

    task automatic check(string what, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic cyc();
        bit e_start;
        bit dn, tn;
        #1;
        e_start = (m_mode == 1) && m_held && bus_brk;
        check("held_req", held_req, m_held);
        check("start_xfer", start_xfer, e_start);
        check("busy", busy, m_mode == 2);
        if (start_xfer === 1'b1) dut_starts++;
        @(posedge clk);
        if (rst) begin
            m_mode = 0; m_held = 0; m_since = 0; m_done = 0; m_tc = 0;
        end else begin
            case (m_mode)
                0: if (en_wr_done) m_mode = 1;
                1: begin
                    if (e_start) begin
                        m_held = 0; m_mode = 2; m_since = 0; m_done = 0; m_tc = 0;
                    end else if (!req_n) begin
                        m_held = 1;
                    end
                end
                default: begin
                    dn = m_done || xfer_done;
                    tn = m_tc || (xfer_done && tc);
                    if (dn && (m_since + 1 >= MIN_CLR)) begin
                        m_mode = tn ? 0 : 1;
                        m_windows++;
                    end else begin
                        m_since++; m_done = dn; m_tc = tn;
                    end
                end
            endcase
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst = 1; en_wr_done = 0; req_n = 0; bus_brk = 0; xfer_done = 0; tc = 0;
        @(posedge clk);
        @(negedge clk);
        // R1: reset and pre-enable with the pin low
        tag = "R1"; repeat (3) cyc();
        rst = 0; repeat (4) cyc();
        // R2: low level only in the strobe cycle is not taken
        tag = "R2"; en_wr_done = 1; req_n = 0; cyc();
        en_wr_done = 0; req_n = 1; cyc(); cyc();
        req_n = 0; cyc();
        // R3: held request persists while pin returns high
        tag = "R3"; req_n = 1; repeat (4) cyc();
        // R4: grant consumes
        tag = "R4"; bus_brk = 1; cyc();
        // R5: grant kept high gives no second pulse
        tag = "R5"; cyc(); cyc();
        // R6: pin low while busy is ignored
        tag = "R6"; req_n = 0; repeat (3) cyc();
        // R7: late completion then reopen with pin still low
        tag = "R7"; xfer_done = 1; cyc(); xfer_done = 0;
        req_n = 1; cyc();
        req_n = 0; bus_brk = 0; cyc(); cyc();
        bus_brk = 1; cyc();
        // R7: completion right after start, minimum window holds busy
        xfer_done = 1; bus_brk = 0; cyc(); xfer_done = 0; repeat (4) cyc();
        // R9: strobe while open/busy, done while open
        tag = "R9"; xfer_done = 1; en_wr_done = 1; cyc(); xfer_done = 0;
        bus_brk = 1; cyc(); en_wr_done = 1; bus_brk = 0; cyc(); cyc();
        en_wr_done = 0; xfer_done = 1; cyc(); xfer_done = 0; repeat (2) cyc();
        // R8: terminal count returns to idle, pin ignored until strobe
        tag = "R8"; bus_brk = 1; cyc(); bus_brk = 0;
        xfer_done = 1; tc = 1; cyc(); xfer_done = 0; tc = 0;
        repeat (5) cyc();
        en_wr_done = 1; cyc(); en_wr_done = 0; repeat (3) cyc();
        // R10: continuous low pin, random grants and completions
        tag = "R10"; req_n = 0; m_windows = 0; dut_starts = 0;
        for (int i = 0; i < 600; i++) begin
            bus_brk = 1'($urandom_range(0, 1));
            xfer_done = ($urandom_range(0, 3) == 0);
            cyc();
        end
        bus_brk = 0; xfer_done = 1; repeat (3) cyc(); xfer_done = 0; cyc();
        vectors++;
        if (dut_starts != m_windows) begin
            miscompares++;
            $display("FAIL R10 transfers: actual %0d expected %0d", dut_starts, m_windows);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule